// File: doc/BRIEF.md
# External status change interrupt unit

This block watches the line and status sources of one serial communications channel and raises a single interrupt when any enabled source changes state. Five sources are levels: receiver break/abort, the transmit underrun/end-of-message latch, the CTS pin, a shared sync/hunt source, and the DCD pin. The sixth source is an event: the baud-rate counter reaching zero. The sync/hunt source is the synchronized SYNC pin when the channel runs asynchronously, and the receiver hunt flag when it runs in a synchronous mode. The block detects a change in either direction, not just one edge.

Software writes an 8-bit enable register. When an enabled change occurs, the block latches the current source levels into a status snapshot and holds the interrupt. The snapshot stays frozen until the CPU issues the interrupt-reset command. One cycle after that command the interrupt drops. In the following cycle it rises again if the live sources no longer match the snapshot, so no change is lost.

The enable register also carries a frame-status-FIFO enable, which only takes effect in SDLC mode, and an enhancement flag that is stored and brought out unchanged.

Top module: `ext_stat_irq`

## Requirements
- R1: After hardware reset, `cfg_q` reads 0xF8 (bits 7..3 set, bits 2..0 clear), `irq` is low and `stat_o` is 0 while all sources are low.
- R2: With the enable bit set, a rise and also a fall of a level source set `irq`. The enable bits are: bit 7 break/abort, bit 6 end-of-message, bit 5 CTS, bit 4 sync/hunt, bit 3 DCD.
- R3: CTS, DCD and SYNC pass through `SYNC_STAGES` flops, so a pin change shows on `irq` exactly `SYNC_STAGES`+1 rising edges later. `brk_abort` and `tx_eom` show after one edge.
- R4: While `irq` is high, `stat_o[5:1]` (bit 5 break, bit 4 end-of-message, bit 3 CTS, bit 2 sync/hunt, bit 1 DCD) holds the levels latched when the interrupt arose, and further source changes do not alter it.
- R5: The edge that samples `irq_clr` high takes `irq` low. If a live level then differs from the snapshot, `irq` rises again on the next edge and `stat_o` takes the new levels.
- R6: A change on a source whose enable bit is 0 leaves `irq` low.
- R7: With `sync_mode`=0 the sync/hunt source is the SYNC pin and `rx_hunt` is ignored. With `sync_mode`=1 it is `rx_hunt` and the SYNC pin is ignored.
- R8: A `bg_zero` pulse with enable bit 1 set raises `irq` and sets `stat_o[0]`, and `irq_clr` clears that bit. With bit 1 clear the pulse is ignored.
- R9: `fifo_en` is high only when enable bit 2 is set and `sdlc_mode` is high. `enh_en` follows enable bit 0.
- R10: A `chan_rst` pulse restores `cfg_q` to 0xF8 and drops `irq` on the next edge without raising a new interrupt.
- R11: A write (`wr_en` high) loads `wr_data` into `cfg_q` on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_rst | input | 1 | Synchronous channel reset pulse |
| wr_en | input | 1 | Enable register write strobe |
| wr_data | input | 8 | Enable register write data |
| irq_clr | input | 1 | Interrupt-reset command pulse |
| sync_mode | input | 1 | 1 = synchronous mode (hunt flag source) |
| sdlc_mode | input | 1 | 1 = channel in SDLC mode |
| brk_abort | input | 1 | Receiver break/abort status |
| tx_eom | input | 1 | Transmit underrun/end-of-message latch |
| cts_pin | input | 1 | CTS pin, asynchronous |
| dcd_pin | input | 1 | DCD pin, asynchronous |
| sync_pin | input | 1 | SYNC pin, asynchronous |
| rx_hunt | input | 1 | Receiver hunt flag |
| bg_zero | input | 1 | Baud counter reached zero, one-cycle pulse |
| cfg_q | output | 8 | Enable register readback |
| stat_o | output | 6 | Status snapshot; bit 0 is the zero-count flag |
| irq | output | 1 | External/status interrupt |
| fifo_en | output | 1 | Frame-status FIFO enable, gated by SDLC mode |
| enh_en | output | 1 | Enhancement enable flag |

## Verification
The bench builds the block with `SYNC_STAGES`=3 instead of the default 2, so the pin latency check depends on the parameter and does not happen to match a fixed two-flop chain. It keeps the default reset value 0xF8, so the reset checks also confirm that the zero-count source starts disabled. This setup makes the exact count of cycles from pin to interrupt observable. It also brings the re-raise after the interrupt-reset command into reach.

// File: rtl/esi_pkg.sv
package esi_pkg;
   localparam int CFG_W   = 8;
   localparam int SRC_N   = 5;
   // live source vector positions
   localparam int S_DCD   = 0;
   localparam int S_SYNC  = 1;
   localparam int S_CTS   = 2;
   localparam int S_EOM   = 3;
   localparam int S_BRK   = 4;
   // enable register positions
   localparam int E_ENH   = 0;
   localparam int E_ZC    = 1;
   localparam int E_FIFO  = 2;
   localparam int E_LVL_LO = 3;
   localparam logic [CFG_W-1:0] CFG_RST_DEF = 8'hF8;
endpackage

// File: rtl/esi_sync.sv
module esi_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_depth
      $error("esi_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/esi_cfg.sv
module esi_cfg #(
   parameter int                CFG_W  = 8,
   parameter logic [CFG_W-1:0]  RST_V  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_rst,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [CFG_W-1:0] cfg_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= RST_V;
      else if (chan_rst) cfg_q <= RST_V;
      else if (wr_en)    cfg_q <= wr_data;
   end
endmodule

// File: rtl/esi_core.sv
module esi_core #(
   parameter int SRC_N = 5,
   parameter int WARM  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_rst,
   input  logic [SRC_N-1:0] live,
   input  logic [SRC_N-1:0] mask,
   input  logic             zev,
   input  logic             clr,
   output logic             pend,
   output logic [SRC_N-1:0] snap,
   output logic             zc_q
);
   localparam int WC_W = $clog2(WARM + 1);

   logic [WC_W-1:0]  warm_cnt;
   logic             warm_done;
   logic [SRC_N-1:0] diff;
   logic             chg;

   assign warm_done = (warm_cnt == WC_W'(WARM));

   // per-source change flags
   for (genvar k = 0; k < SRC_N; k++) begin : g_diff
      assign diff[k] = (live[k] ^ snap[k]) & mask[k];
   end

   assign chg = warm_done & ~pend & (|diff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          warm_cnt <= '0;
      else if (!warm_done) warm_cnt <= warm_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         snap <= '0;
         zc_q <= 1'b0;
      end else if (chan_rst) begin
         pend <= 1'b0;
         snap <= live;
         zc_q <= 1'b0;
      end else begin
         pend <= (pend & ~clr) | chg | zev;
         zc_q <= (zc_q & ~clr) | zev;
         if (!pend) snap <= live;
      end
   end
endmodule

// File: rtl/ext_stat_irq.sv
module ext_stat_irq #(
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  EN_RST      = esi_pkg::CFG_RST_DEF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       chan_rst,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       irq_clr,
   input  logic       sync_mode,
   input  logic       sdlc_mode,
   input  logic       brk_abort,
   input  logic       tx_eom,
   input  logic       cts_pin,
   input  logic       dcd_pin,
   input  logic       sync_pin,
   input  logic       rx_hunt,
   input  logic       bg_zero,
   output logic [7:0] cfg_q,
   output logic [5:0] stat_o,
   output logic       irq,
   output logic       fifo_en,
   output logic       enh_en
);
   import esi_pkg::*;

   localparam int PIN_N = 3;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("ext_stat_irq: SYNC_STAGES below 2");
   end
   if (CFG_W != 8) begin : g_chk_cfg
      $error("ext_stat_irq: enable register must be 8 bits");
   end

   logic [PIN_N-1:0] pin_raw, pin_s;
   logic [SRC_N-1:0] live, mask, snap;
   logic             sync_src, zev, pend, zc_q;

   assign pin_raw = {cts_pin, sync_pin, dcd_pin};

   esi_sync #(.STAGES(SYNC_STAGES), .W(PIN_N)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (pin_s)
   );

   esi_cfg #(.CFG_W(CFG_W), .RST_V(EN_RST)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .chan_rst (chan_rst),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .cfg_q    (cfg_q)
   );

   assign sync_src     = sync_mode ? rx_hunt : pin_s[1];
   assign live[S_DCD]  = pin_s[0];
   assign live[S_SYNC] = sync_src;
   assign live[S_CTS]  = pin_s[2];
   assign live[S_EOM]  = tx_eom;
   assign live[S_BRK]  = brk_abort;

   assign mask = cfg_q[E_LVL_LO +: SRC_N];
   assign zev  = bg_zero & cfg_q[E_ZC];

   esi_core #(.SRC_N(SRC_N), .WARM(SYNC_STAGES)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .chan_rst (chan_rst),
      .live     (live),
      .mask     (mask),
      .zev      (zev),
      .clr      (irq_clr),
      .pend     (pend),
      .snap     (snap),
      .zc_q     (zc_q)
   );

   assign irq     = pend;
   assign stat_o  = {snap, zc_q};
   assign fifo_en = cfg_q[E_FIFO] & sdlc_mode;
   assign enh_en  = cfg_q[E_ENH];
endmodule

// File: rtl/esi_chk.sv
module esi_chk #(
   parameter logic [7:0] EN_RST = 8'hF8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       chan_rst,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic       irq_clr,
   input logic       bg_zero,
   input logic [7:0] cfg_q,
   input logic [5:0] stat_o,
   input logic       irq
);
   p_chan_rst_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst |=> (cfg_q == EN_RST) && !irq);

   p_write_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !chan_rst |=> cfg_q == $past(wr_data));

   p_clr_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq && irq_clr && !(bg_zero && cfg_q[1]) |=> !irq);

   p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !irq_clr && !chan_rst |=> $stable(stat_o[5:1]));

   p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq && (cfg_q[7:3] == 5'd0) && !(bg_zero && cfg_q[1]) && !chan_rst |=> !irq);

   p_zero_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bg_zero && cfg_q[1] && !chan_rst |=> irq && stat_o[0]);
endmodule

bind ext_stat_irq esi_chk #(.EN_RST(EN_RST)) u_chk (.*);

// File: tb/sim_ext_stat_irq.sv
module sim_ext_stat_irq;
   localparam int CLK_PER = 10;
   localparam int SYNC_N  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chan_rst = 1'b0, wr_en = 1'b0, irq_clr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       sync_mode = 1'b0, sdlc_mode = 1'b0;
   logic       brk_abort = 1'b0, tx_eom = 1'b0, cts_pin = 1'b0, dcd_pin = 1'b0;
   logic       sync_pin = 1'b0, rx_hunt = 1'b0, bg_zero = 1'b0;
   logic [7:0] cfg_q;
   logic [5:0] stat_o;
   logic       irq, fifo_en, enh_en;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PER/2) clk = ~clk;

   ext_stat_irq #(.SYNC_STAGES(SYNC_N)) u0 (.*);

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_clr();
      irq_clr = 1'b1;
      cyc(1);
      irq_clr = 1'b0;
      cyc(1);
   endtask

   task automatic do_wr(input logic [7:0] v);
      wr_en = 1'b1; wr_data = v;
      cyc(1);
      wr_en = 1'b0;
      chk("R11 cfg write", cfg_q, v);
   endtask

   task automatic t_reset();
      chk("R1 cfg default", cfg_q, 8'hF8);
      chk("R1 irq low", {7'd0, irq}, 8'd0);
      chk("R1 status zero", {2'd0, stat_o}, 8'd0);
   endtask

   task automatic t_pin_latency();
      cts_pin = 1'b1;
      cyc(SYNC_N);
      chk("R3 no early irq", {7'd0, irq}, 8'd0);
      cyc(1);
      chk("R3 irq after sync", {7'd0, irq}, 8'd1);
      chk("R2 cts status", {2'd0, stat_o}, 8'h08);
      do_clr();
      cts_pin = 1'b0;
      cyc(SYNC_N + 1);
      chk("R2 cts fall irq", {7'd0, irq}, 8'd1);
      do_clr();
      chk("R5 cleared", {7'd0, irq}, 8'd0);
   endtask

   task automatic t_hold_rearm();
      brk_abort = 1'b1;
      cyc(1);
      chk("R2 brk rise", {7'd0, irq}, 8'd1);
      dcd_pin = 1'b1;
      cyc(SYNC_N + 2);
      chk("R4 snapshot frozen", {2'd0, stat_o}, 8'h20);
      irq_clr = 1'b1;
      cyc(1);
      irq_clr = 1'b0;
      chk("R5 drop after clr", {7'd0, irq}, 8'd0);
      cyc(1);
      chk("R5 rearm", {7'd0, irq}, 8'd1);
      chk("R5 new snapshot", {2'd0, stat_o}, 8'h22);
      do_clr();
      brk_abort = 1'b0;
      cyc(1);
      chk("R2 brk fall", {7'd0, irq}, 8'd1);
      chk("R2 brk fall status", {2'd0, stat_o}, 8'h02);
      do_clr();
      dcd_pin = 1'b0;
      cyc(SYNC_N + 2);
      do_clr();
   endtask

   task automatic t_sync_sel();
      sync_pin = 1'b1;
      cyc(SYNC_N + 1);
      chk("R7 async pin", {2'd0, stat_o}, 8'h04);
      do_clr();
      rx_hunt = 1'b1;
      cyc(2);
      chk("R7 hunt ignored async", {7'd0, irq}, 8'd0);
      sync_mode = 1'b1;
      sync_pin = 1'b0;
      cyc(SYNC_N + 2);
      chk("R7 pin ignored sync", {7'd0, irq}, 8'd0);
      rx_hunt = 1'b0;
      cyc(1);
      chk("R7 hunt change", {7'd0, irq}, 8'd1);
      do_clr();
      sync_mode = 1'b0;
      cyc(2);
      chk("R7 back async quiet", {7'd0, irq}, 8'd0);
   endtask

   task automatic t_zero();
      bg_zero = 1'b1; cyc(1); bg_zero = 1'b0;
      cyc(1);
      chk("R8 zero disabled", {7'd0, irq}, 8'd0);
      do_wr(8'hFA);
      bg_zero = 1'b1; cyc(1); bg_zero = 1'b0;
      chk("R8 zero irq", {7'd0, irq}, 8'd1);
      chk("R8 zero flag", {7'd0, stat_o[0]}, 8'd1);
      do_clr();
      chk("R8 flag cleared", {2'd0, stat_o}, 8'd0);
   endtask

   task automatic t_masked();
      do_wr(8'h05);
      chk("R9 enh flag", {7'd0, enh_en}, 8'd1);
      chk("R9 fifo off async", {7'd0, fifo_en}, 8'd0);
      sdlc_mode = 1'b1;
      cyc(1);
      chk("R9 fifo in sdlc", {7'd0, fifo_en}, 8'd1);
      sdlc_mode = 1'b0;
      cts_pin = 1'b1; brk_abort = 1'b1; tx_eom = 1'b1;
      cyc(SYNC_N + 2);
      chk("R6 masked ignored", {7'd0, irq}, 8'd0);
      cts_pin = 1'b0; brk_abort = 1'b0; tx_eom = 1'b0;
      cyc(SYNC_N + 2);
      chk("R6 masked fall ignored", {7'd0, irq}, 8'd0);
   endtask

   task automatic t_chan_rst();
      do_wr(8'hF8);
      tx_eom = 1'b1;
      cyc(1);
      chk("R2 eom rise", {2'd0, stat_o}, 8'h10);
      chan_rst = 1'b1;
      cyc(1);
      chan_rst = 1'b0;
      chk("R10 irq dropped", {7'd0, irq}, 8'd0);
      do_wr(8'h00);
      chan_rst = 1'b1;
      cyc(1);
      chan_rst = 1'b0;
      chk("R10 cfg restored", cfg_q, 8'hF8);
      cyc(2);
      chk("R10 no new irq", {7'd0, irq}, 8'd0);
      tx_eom = 1'b0;
      cyc(1);
      chk("R2 eom fall", {7'd0, irq}, 8'd1);
      do_clr();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      cyc(3);
      rst_n = 1'b1;
      cyc(8);
      t_reset();
      t_pin_latency();
      t_hold_rearm();
      t_sync_sel();
      t_zero();
      t_masked();
      t_chan_rst();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule